// File: doc/BRIEF.md
# Link Training Pattern Generator

This block supplies the per-lane byte stream that a serial display transmitter sends while the link is being trained. A small select input picks one of four fixed training sequences or an idle state. The chosen sequence repeats for as long as the selection is held. Each byte leaves the block with a flag that tells the downstream 8b/10b encoder whether to emit it as a control (K) symbol or as a data (D) symbol.

Training patterns are never scrambled, so the block raises a bypass output for the scrambler whenever a pattern is active. It also reports which training phase the selected pattern belongs to. Clock recovery uses the single-symbol pattern. Equalization, symbol lock and lane alignment use the three longer patterns. When the selection changes, the sequence restarts, so the new pattern always begins with its first symbol.

Symbol bytes are built from their code-group names: for a symbol Dx.y or Kx.y, the low five bits hold x and the high three bits hold y.

Top module: `lt_pattern_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every output is 0 on the next cycle: tx_byte 0x00, and tx_is_k, tx_valid, scr_bypass, cr_phase and eq_phase all low.
- R2: train_sel codes are 0 = idle, 1 = pattern 1, 2 = pattern 2, 3 = pattern 3, 4 = pattern 4, and 5 to 7 = idle. When idle, tx_byte is 0x00 and tx_is_k, tx_valid, scr_bypass, cr_phase and eq_phase are all 0.
- R3: Pattern 1 sends the byte 0x4A (D10.2) every cycle with tx_is_k = 0.
- R4: Pattern 2 repeats a five-byte cycle: 0xBC (K), 0xCB (D), 0xBC (K), 0xCB (D), 0x4A (D).
- R5: Pattern 3 repeats a four-byte cycle: 0xBC (K), 0x4A (D), 0xBC (K), 0x7E (D).
- R6: Pattern 4 repeats 0x1C (K), 0xBC (K), 0x1C (K), followed by FILL_LEN bytes of 0x00 (D). With the default FILL_LEN of 248, the period is 251 bytes.
- R7: tx_is_k is 1 only for the bytes 0xBC (K28.5) and 0x1C (K28.0) inside a pattern. It is 0 for every data byte and every zero fill byte.
- R8: Outputs are registered, so they reflect train_sel one clock after it is sampled. A change of train_sel restarts the sequence, and the byte emitted at the first edge after the change is the new pattern's first symbol.
- R9: tx_valid and scr_bypass are both 1 exactly when train_sel selects a pattern (codes 1 to 4).
- R10: cr_phase is 1 for pattern 1. eq_phase is 1 for patterns 2, 3 and 4. The two are never 1 together.
- R11: While train_sel is held, the sequence advances one byte per cycle and wraps from its last byte back to its first without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_sel | input | 3 | Pattern select: 0 idle, 1 to 4 pattern, 5 to 7 idle |
| tx_byte | output | 8 | Byte for the 8b/10b encoder |
| tx_is_k | output | 1 | Encode tx_byte as a control symbol |
| tx_valid | output | 1 | tx_byte carries a pattern byte |
| scr_bypass | output | 1 | Scrambler must pass the byte through unchanged |
| cr_phase | output | 1 | Clock-recovery pattern active |
| eq_phase | output | 1 | Equalization/alignment pattern active |

## Verification
Every output of this block goes through exactly one register. A value of train_sel applied between edges therefore shows up after the next rising edge as index 0 of its pattern, and after the n-th following edge as index n. The bench changes train_sel on the falling edge and samples one half period after each rising edge. It compares the sample against the symbol it computes for the step count since the change, with the count taken modulo the pattern's period. Reset also acts at the next edge, so the cleared state is sampled after that edge. After reset is released, the first byte is index 0 of the pattern still selected.

// File: rtl/lt_pkg.sv
// Shared definitions for the link training pattern generator.
// Symbol bytes are composed from their code-group name: {y, x}.
package lt_pkg;

    typedef enum logic [2:0] {
        SEL_IDLE = 3'd0,
        SEL_TPS1 = 3'd1,
        SEL_TPS2 = 3'd2,
        SEL_TPS3 = 3'd3,
        SEL_TPS4 = 3'd4
    } lt_sel_e;

    // Build the byte of symbol Dx.y / Kx.y: x is bits 4:0, y is bits 7:5.
    function automatic logic [7:0] sym_byte(input logic [4:0] x, input logic [2:0] y);
        return {y, x};
    endfunction

    localparam logic [7:0] SYM_D10_2 = sym_byte(5'd10, 3'd2);  // 0x4A
    localparam logic [7:0] SYM_D11_6 = sym_byte(5'd11, 3'd6);  // 0xCB
    localparam logic [7:0] SYM_D30_3 = sym_byte(5'd30, 3'd3);  // 0x7E
    localparam logic [7:0] SYM_K28_5 = sym_byte(5'd28, 3'd5);  // 0xBC
    localparam logic [7:0] SYM_K28_0 = sym_byte(5'd28, 3'd0);  // 0x1C

    localparam int TPS2_PERIOD = 5;
    localparam int TPS3_PERIOD = 4;
    localparam int TPS4_HEAD   = 3;

endpackage

// File: rtl/lt_seq_counter.sv
// Sequence index counter.
// Produces the index of the symbol to emit this cycle. A restart forces
// index 0 in the same cycle; the stored index then continues from 1.
// Assumes len >= 1 and that len only changes together with a restart.
module lt_seq_counter #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [IDX_W-1:0] len,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;

    // Effective index: zero on restart, else the stored position.
    always_comb begin
        idx     = restart ? '0 : idx_q;
        idx_nxt = idx + IDX_W'(1);
    end

    // Advance by one and wrap at the pattern period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_nxt >= len) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_nxt;
        end
    end

    // R11: a held selection never leaves the stored index outside its period
    idx_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (idx_q < len));

endmodule

// File: rtl/lt_symbol_map.sv
// Symbol map: turns (selection, index) into the byte, its K flag, the
// pattern period and the phase indications. Purely combinational.
// Assumes idx < period of the selected pattern.
module lt_symbol_map
    import lt_pkg::*;
#(
    parameter int FILL_LEN = 248,
    parameter int IDX_W    = 8
) (
    input  logic [2:0]       sel,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       sym,
    output logic             is_k,
    output logic             active,
    output logic             cr,
    output logic             eq,
    output logic [IDX_W-1:0] len
);

    localparam int TPS4_PERIOD = TPS4_HEAD + FILL_LEN;

    // Select the symbol and the attributes of the chosen pattern.
    always_comb begin
        sym    = 8'h00;
        is_k   = 1'b0;
        active = 1'b0;
        cr     = 1'b0;
        eq     = 1'b0;
        len    = IDX_W'(1);
        case (sel)
            SEL_TPS1: begin
                active = 1'b1;
                cr     = 1'b1;
                sym    = SYM_D10_2;
            end
            SEL_TPS2: begin
                active = 1'b1;
                eq     = 1'b1;
                len    = IDX_W'(TPS2_PERIOD);
                case (idx)
                    IDX_W'(0), IDX_W'(2): begin sym = SYM_K28_5; is_k = 1'b1; end
                    IDX_W'(1), IDX_W'(3): sym = SYM_D11_6;
                    default:              sym = SYM_D10_2;
                endcase
            end
            SEL_TPS3: begin
                active = 1'b1;
                eq     = 1'b1;
                len    = IDX_W'(TPS3_PERIOD);
                case (idx)
                    IDX_W'(0), IDX_W'(2): begin sym = SYM_K28_5; is_k = 1'b1; end
                    IDX_W'(1):            sym = SYM_D10_2;
                    default:              sym = SYM_D30_3;
                endcase
            end
            SEL_TPS4: begin
                active = 1'b1;
                eq     = 1'b1;
                len    = IDX_W'(TPS4_PERIOD);
                case (idx)
                    IDX_W'(0), IDX_W'(2): begin sym = SYM_K28_0; is_k = 1'b1; end
                    IDX_W'(1):            begin sym = SYM_K28_5; is_k = 1'b1; end
                    default:              sym = 8'h00;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lt_pattern_gen.sv
// Link training pattern generator (top).
// Registers the selection to detect changes, drives the sequence counter
// and the symbol map, and registers all outputs (one cycle latency).
// Assumes train_sel is synchronous to clk.
module lt_pattern_gen
    import lt_pkg::*;
#(
    parameter int FILL_LEN = 248
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] train_sel,
    output logic [7:0] tx_byte,
    output logic       tx_is_k,
    output logic       tx_valid,
    output logic       scr_bypass,
    output logic       cr_phase,
    output logic       eq_phase
);

    localparam int MAX_PERIOD = TPS4_HEAD + FILL_LEN;
    localparam int IDX_W      = $clog2(MAX_PERIOD + 1);

    logic [2:0]       sel_q;
    logic             restart;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] len;
    logic [7:0]       m_sym;
    logic             m_k, m_active, m_cr, m_eq;

    // Remember the selection of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_IDLE;
        else        sel_q <= train_sel;
    end

    // Any change of selection restarts the sequence.
    assign restart = (train_sel != sel_q);

    lt_seq_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .len     (len),
        .idx     (idx)
    );

    lt_symbol_map #(.FILL_LEN(FILL_LEN), .IDX_W(IDX_W)) u_map (
        .sel    (train_sel),
        .idx    (idx),
        .sym    (m_sym),
        .is_k   (m_k),
        .active (m_active),
        .cr     (m_cr),
        .eq     (m_eq),
        .len    (len)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte    <= 8'h00;
            tx_is_k    <= 1'b0;
            tx_valid   <= 1'b0;
            scr_bypass <= 1'b0;
            cr_phase   <= 1'b0;
            eq_phase   <= 1'b0;
        end else begin
            tx_byte    <= m_sym;
            tx_is_k    <= m_k;
            tx_valid   <= m_active;
            scr_bypass <= m_active;
            cr_phase   <= m_cr;
            eq_phase   <= m_eq;
        end
    end

    // R7
    k_only_on_k28_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_is_k |-> (tx_valid && (tx_byte == SYM_K28_5 || tx_byte == SYM_K28_0)));

    // R2
    idle_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> (tx_byte == 8'h00 && !tx_is_k && !cr_phase && !eq_phase));

    // R10
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cr_phase, eq_phase}));

    // R9
    bypass_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_phase || eq_phase) |-> (tx_valid && scr_bypass));

    // R8
    restart_first_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && (train_sel == SEL_TPS3 || train_sel == SEL_TPS2))
        |=> (tx_byte == SYM_K28_5 && tx_is_k));

    // R3
    cr_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_phase |-> (tx_byte == SYM_D10_2 && !tx_is_k));

endmodule

// File: tb/lt_pattern_gen_test.sv
`timescale 1ns/1ps
module lt_pattern_gen_test;

    localparam int FILL = 248;
    localparam int P4   = 3 + FILL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] train_sel = 3'd0;
    logic [7:0] tx_byte;
    logic       tx_is_k, tx_valid, scr_bypass, cr_phase, eq_phase;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;  // 250 MHz

    lt_pattern_gen #(.FILL_LEN(FILL)) uut (
        .clk(clk), .rst_n(rst_n), .train_sel(train_sel),
        .tx_byte(tx_byte), .tx_is_k(tx_is_k), .tx_valid(tx_valid),
        .scr_bypass(scr_bypass), .cr_phase(cr_phase), .eq_phase(eq_phase)
    );

    // Stimulus table: {select[12:10], steps[9:0]}; neighbours differ in select.
    localparam logic [12:0] VEC [10] = '{
        {3'd1, 10'd6}, {3'd2, 10'd12}, {3'd3, 10'd9}, {3'd4, 10'd520},
        {3'd0, 10'd3}, {3'd2, 10'd3},  {3'd3, 10'd5}, {3'd7, 10'd3},
        {3'd5, 10'd2}, {3'd1, 10'd2}
    };

    // Expected {byte, k, valid, bypass, cr, eq} at step i of select s.
    function automatic logic [12:0] expect_vec(input logic [2:0] s, input int i);
        logic [7:0] b = 8'h00;
        logic k = 1'b0;
        case (s)
            3'd1: return {8'h4A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            3'd2: begin
                case (i % 5)
                    0, 2:    begin b = 8'hBC; k = 1'b1; end
                    1, 3:    b = 8'hCB;
                    default: b = 8'h4A;
                endcase
                return {b, k, 1'b1, 1'b1, 1'b0, 1'b1};
            end
            3'd3: begin
                case (i % 4)
                    0, 2:    begin b = 8'hBC; k = 1'b1; end
                    1:       b = 8'h4A;
                    default: b = 8'h7E;
                endcase
                return {b, k, 1'b1, 1'b1, 1'b0, 1'b1};
            end
            3'd4: begin
                case (i % P4)
                    0, 2:    begin b = 8'h1C; k = 1'b1; end
                    1:       begin b = 8'hBC; k = 1'b1; end
                    default: b = 8'h00;
                endcase
                return {b, k, 1'b1, 1'b1, 1'b0, 1'b1};
            end
            default: return 13'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R2";
        endcase
    endfunction

    // One check: byte/K (R7), valid/bypass (R9), phases (R10), step count (R11).
    task automatic check(input string req, input logic [12:0] exp_v);
        logic [12:0] got;
        got = {tx_byte, tx_is_k, tx_valid, scr_bypass, cr_phase, eq_phase};
        total++;
        if (got !== exp_v) begin
            bad++;
            $display("FAIL %s got=%h expected=%h (byte,k,valid,bypass,cr,eq)", req, got, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 13'h0);
        train_sel = 3'd4;
        step();
        check("R1 with select held during reset", 13'h0);
        rst_n = 1'b1;
        train_sel = 3'd0;
        step();

        // Table walk (R2..R6, R8 restart on every change, R11 wrap)
        foreach (VEC[v]) begin
            train_sel = VEC[v][12:10];
            for (int i = 0; i < int'(VEC[v][9:0]); i++) begin
                step();
                check(req_of(VEC[v][12:10]), expect_vec(VEC[v][12:10], i));
            end
        end

        // R8: mid-pattern switch from pattern 2 to pattern 3
        train_sel = 3'd2;
        step(); check("R8", expect_vec(3'd2, 0));
        step(); check("R8", expect_vec(3'd2, 1));
        train_sel = 3'd3;
        step(); check("R8 restart", expect_vec(3'd3, 0));
        step(); check("R8", expect_vec(3'd3, 1));
        // R8: switch back, pattern 2 starts over
        train_sel = 3'd2;
        step(); check("R8 restart", expect_vec(3'd2, 0));

        // R1: reset in the middle of pattern 4, then restart from its first symbol
        train_sel = 3'd4;
        step(); step();
        rst_n = 1'b0;
        step(); check("R1 mid-pattern", 13'h0);
        rst_n = 1'b1;
        step(); check("R8 after reset", expect_vec(3'd4, 0));
        step(); check("R6", expect_vec(3'd4, 1));
        step(); check("R6", expect_vec(3'd4, 2));
        step(); check("R6 fill", expect_vec(3'd4, 3));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule